// File: doc/BRIEF.md
# Sixteen-Line Interrupt Gatherer

This block gathers up to sixteen external interrupt sources into one level-high request line for a host processor. Each source passes through a short synchroniser. A rising edge on the synchronised copy latches a per-line status bit, whether or not that line is enabled. A per-line enable mask selects which latched lines count as pending. The request output stays high for as long as any line is pending.

Software changes the mask through two write-only views. One view sets enable bits and the other clears them, so a single line can be enabled or disabled without a read-modify-write. Status bits are cleared by writing ones to the status address. A read-only pending view and a lowest-pending-line index let a handler find its next line without scanning the bits.

Top module: `irq_gather`

## Requirements
- R1: While reset is held and in the first cycle after it, every status bit and every enable bit is 0. The request output and the valid flag are low, and the index is 0.
- R2: A 0-to-1 change on a source input sets that line's status bit three clock edges later, whatever the state of its enable bit. A source held at a constant level sets nothing.
- R3: A write to address 1 sets each enable bit whose write-data bit is 1. Enable bits whose data bit is 0 keep their value.
- R4: A write to address 2 clears each enable bit whose write-data bit is 1. Enable bits whose data bit is 0 keep their value.
- R5: A write to address 0 clears each status bit whose write-data bit is 1. Status bits whose data bit is 0 keep their value.
- R6: If a new source edge reaches a status bit in the same cycle that a write clears that bit, the bit stays set.
- R7: The request output is high exactly while some line has both its status bit and its enable bit at 1. It stays high until every such line is cleared or disabled.
- R8: The valid flag is high while any line is pending. The 4-bit index then gives the lowest-numbered pending line. With nothing pending, the index is 0.
- R9: Read data is combinational from the address. Address 0 returns status, addresses 1 and 2 both return the enable mask, and address 3 returns status AND mask. A write to address 3 changes nothing.
- R10: Writing 0xFFFF to address 2 and then 0xFFFF to address 0 leaves every line disabled and every status bit 0, provided no source rises meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Asynchronous interrupt source inputs |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the selected register |
| irq_o | output | 1 | Level-high request to the host |
| pend_valid_o | output | 1 | High when any line is pending |
| pend_idx_o | output | 4 | Lowest-numbered pending line |

## Verification
The bench builds the block at its defaults: sixteen lines and a two-stage synchroniser. At sixteen lines, bit 15 and index 15 are reachable, and the priority encoder is exercised across its full width. With two synchroniser stages the edge-to-status delay is a fixed three edges, so the bench can line up a clearing write with an arriving edge on the exact cycle R6 names. A behavioural model with a queue for the synchroniser predicts every output on every clock, under both directed writes and random traffic.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    localparam int BUS_ADDR_W = 2;

    typedef enum logic [BUS_ADDR_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_EN_SET = 2'd1,
        SEL_EN_CLR = 2'd2,
        SEL_PEND   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irqg_edge.sv
// Per-line synchroniser chain followed by a rising-edge detector.
module irqg_edge #(
    parameter int N_LINES = 16,
    parameter int STAGES  = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_LINES-1:0] src_i,
    output logic [N_LINES-1:0] rise_o
);

    typedef struct packed {
        logic [STAGES-1:0][N_LINES-1:0] chain;
        logic [N_LINES-1:0]             last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.chain[0] = src_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.chain[i] = sync_q.chain[i-1];
        end
        sync_d.last = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rise_o = sync_q.chain[STAGES-1] & ~sync_q.last;

endmodule

// File: rtl/irqg_regs.sv
// Status and enable registers with set/clear views and a read mux.
module irqg_regs
    import irqg_pkg::*;
#(
    parameter int N_LINES = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  we_i,
    input  logic [BUS_ADDR_W-1:0] addr_i,
    input  logic [N_LINES-1:0]    wdata_i,
    input  logic [N_LINES-1:0]    rise_i,
    output logic [N_LINES-1:0]    status_o,
    output logic [N_LINES-1:0]    mask_o,
    output logic [N_LINES-1:0]    rdata_o
);

    typedef struct packed {
        logic [N_LINES-1:0] status;
        logic [N_LINES-1:0] mask;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [N_LINES-1:0] wipe;

    always_comb begin
        regs_d = regs_q;
        wipe   = '0;
        if (we_i) begin
            unique case (reg_sel_e'(addr_i))
                SEL_STATUS: wipe        = wdata_i;
                SEL_EN_SET: regs_d.mask = regs_q.mask | wdata_i;
                SEL_EN_CLR: regs_d.mask = regs_q.mask & ~wdata_i;
                SEL_PEND:   ;
                default:    ;
            endcase
        end
        // a fresh edge outranks a clearing write on the same bit
        regs_d.status = (regs_q.status & ~wipe) | rise_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(addr_i))
            SEL_STATUS: rdata_o = regs_q.status;
            SEL_EN_SET: rdata_o = regs_q.mask;
            SEL_EN_CLR: rdata_o = regs_q.mask;
            SEL_PEND:   rdata_o = regs_q.status & regs_q.mask;
            default:    rdata_o = '0;
        endcase
    end

    assign status_o = regs_q.status;
    assign mask_o   = regs_q.mask;

endmodule

// File: rtl/irqg_prio.sv
// Lowest-index-first encoder over the pending vector.
module irqg_prio #(
    parameter int N_LINES = 16,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] pend_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);

    always_comb begin
        any_o = |pend_i;
        idx_o = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irqg_pkg::*;
#(
    parameter int N_LINES     = 16,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(N_LINES)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [N_LINES-1:0]    src_i,
    input  logic                  bus_we_i,
    input  logic [BUS_ADDR_W-1:0] bus_addr_i,
    input  logic [N_LINES-1:0]    bus_wdata_i,
    output logic [N_LINES-1:0]    bus_rdata_o,
    output logic                  irq_o,
    output logic                  pend_valid_o,
    output logic [IDX_W-1:0]      pend_idx_o
);

    logic [N_LINES-1:0] rise_w;
    logic [N_LINES-1:0] status_w;
    logic [N_LINES-1:0] mask_w;
    logic [N_LINES-1:0] pend_w;
    logic               any_w;

    irqg_edge #(
        .N_LINES (N_LINES),
        .STAGES  (SYNC_STAGES)
    ) u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .src_i   (src_i),
        .rise_o  (rise_w)
    );

    irqg_regs #(
        .N_LINES (N_LINES)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (bus_we_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .rise_i   (rise_w),
        .status_o (status_w),
        .mask_o   (mask_w),
        .rdata_o  (bus_rdata_o)
    );

    assign pend_w = status_w & mask_w;

    irqg_prio #(
        .N_LINES (N_LINES)
    ) u_prio (
        .pend_i  (pend_w),
        .any_o   (any_w),
        .idx_o   (pend_idx_o)
    );

    assign irq_o        = any_w;
    assign pend_valid_o = any_w;

endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
    import irqg_pkg::*;
#(
    parameter int N_LINES = 16,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  we_i,
    input logic [BUS_ADDR_W-1:0] addr_i,
    input logic [N_LINES-1:0]    wdata_i,
    input logic [N_LINES-1:0]    rise_i,
    input logic [N_LINES-1:0]    status_i,
    input logic [N_LINES-1:0]    mask_i,
    input logic                  irq_i,
    input logic                  valid_i,
    input logic [IDX_W-1:0]      idx_i
);

    a_r1_clear_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!rst_ni) |-> (status_i == '0 && mask_i == '0 && !irq_i));

    a_r2_rise_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i != '0) |=> ((status_i & $past(rise_i)) == $past(rise_i)));

    a_r2_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i == '0) |=> ((status_i & ~$past(status_i)) == '0));

    a_r3_enable_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == SEL_EN_SET) |=> ((mask_i & $past(wdata_i)) == $past(wdata_i)));

    a_r4_enable_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == SEL_EN_CLR) |=> ((mask_i & $past(wdata_i)) == '0));

    a_r5_status_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == SEL_STATUS) |=> ((status_i & $past(wdata_i) & ~$past(rise_i)) == '0));

    a_r7_request_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i == ((status_i & mask_i) != '0));

    a_r8_index_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |-> (status_i[idx_i] && mask_i[idx_i]));

    a_r8_index_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |-> ((status_i & mask_i & ((N_LINES'(1) << idx_i) - N_LINES'(1))) == '0));

endmodule

bind irq_gather irq_gather_chk #(.N_LINES(N_LINES)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rise_i   (rise_w),
    .status_i (status_w),
    .mask_i   (mask_w),
    .irq_i    (irq_o),
    .valid_i  (pend_valid_o),
    .idx_i    (pend_idx_o)
);

// File: tb/irq_gather_bench.sv
module irq_gather_bench;

    localparam int N = 16;
    localparam int S = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         we = 1'b0;
    logic [1:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq;
    logic         valid;
    logic [3:0]   idx;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_gather u_irq_gather (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .src_i        (src),
        .bus_we_i     (we),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .irq_o        (irq),
        .pend_valid_o (valid),
        .pend_idx_o   (idx)
    );

    // behavioural reference
    logic [N-1:0] m_status = '0;
    logic [N-1:0] m_mask   = '0;
    logic [N-1:0] hist[$];
    logic [N-1:0] m_rise;
    logic [N-1:0] m_wipe;

    initial begin
        for (int i = 0; i <= S; i++) hist.push_back('0);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_status = '0;
            m_mask   = '0;
            for (int i = 0; i <= S; i++) hist[i] = '0;
        end else begin
            m_rise = hist[S-1] & ~hist[S];
            m_wipe = (we && addr == 2'd0) ? wdata : '0;
            m_status = (m_status & ~m_wipe) | m_rise;
            if (we && addr == 2'd1) m_mask = m_mask | wdata;
            if (we && addr == 2'd2) m_mask = m_mask & ~wdata;
            hist.push_front(src);
            void'(hist.pop_back());
        end
    end

    function automatic logic [N-1:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_status;
            2'd3:    return m_status & m_mask;
            default: return m_mask;
        endcase
    endfunction

    function automatic int m_lowest();
        logic [N-1:0] p = m_status & m_mask;
        for (int i = 0; i < N; i++) if (p[i]) return i;
        return 0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the reference
    always begin
        @(negedge clk);
        #2;
        chk("R7 request", 32'(irq), 32'((m_status & m_mask) != '0));
        chk("R8 valid", 32'(valid), 32'((m_status & m_mask) != '0));
        chk("R8 index", 32'(idx), 32'(m_lowest()));
        chk("R9 read data", 32'(rdata), 32'(m_read(addr)));
    end

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        #3;
    endtask

    task automatic rd(input logic [1:0] a, input string tag, input logic [N-1:0] exp);
        @(negedge clk);
        addr = a; we = 1'b0;
        #3;
        chk(tag, 32'(rdata), 32'(exp));
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, "R1 status after reset", 16'h0000);
        rd(2'd1, "R1 mask after reset", 16'h0000);
        chk("R1 request low", 32'(irq), 32'd0);

        // R2: edges latch with the line disabled
        @(negedge clk); src = 16'h0005;
        repeat (5) @(negedge clk);
        rd(2'd0, "R2 status latched", 16'h0005);
        chk("R2 request stays low while disabled", 32'(irq), 32'd0);

        wr(2'd1, 16'h0004);
        rd(2'd1, "R3 mask set", 16'h0004);
        chk("R7 request high", 32'(irq), 32'd1);
        wr(2'd1, 16'h8001);
        rd(2'd1, "R3 mask set keeps zeros", 16'h8005);
        wr(2'd2, 16'h0004);
        rd(2'd1, "R4 mask clear", 16'h8001);
        rd(2'd3, "R9 pending view", 16'h0001);
        wr(2'd0, 16'h0001);
        rd(2'd0, "R5 status clear", 16'h0004);
        chk("R7 request falls", 32'(irq), 32'd0);

        // R6: set bit 9, then hit a second edge with a clearing write
        @(negedge clk); src[9] = 1'b1;
        repeat (4) @(negedge clk);
        src[9] = 1'b0;
        repeat (4) @(negedge clk);
        src[9] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr = 2'd0; wdata = 16'h0200; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        rd(2'd0, "R6 edge beats clear", 16'h0204);

        wr(2'd1, 16'hFFFF);
        #1 chk("R8 lowest index", 32'(idx), 32'd2);
        wr(2'd0, 16'h0004);
        #1 chk("R8 next index", 32'(idx), 32'd9);
        wr(2'd3, 16'hFFFF);
        rd(2'd3, "R9 pending write ignored", 16'h0200);
        rd(2'd2, "R9 clear view reads mask", 16'hFFFF);

        wr(2'd2, 16'hFFFF);
        wr(2'd0, 16'hFFFF);
        rd(2'd1, "R10 all disabled", 16'h0000);
        rd(2'd0, "R10 all cleared", 16'h0000);
        chk("R10 request low", 32'(irq), 32'd0);

        // random traffic, compared every cycle
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) src = src ^ N'($urandom);
            we    = ($urandom_range(0, 2) == 0);
            addr  = 2'($urandom);
            wdata = N'($urandom) & N'($urandom);
        end
        @(negedge clk); we = 1'b0;
        repeat (4) @(negedge clk);
        #3;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule